// File: doc/BRIEF.md
# Serial Basic Clock Generator

This block produces the basic clock of one serial channel as a one-cycle enable in the system clock domain. A two-bit source field picks one of four origins for that enable: every second tick of a baud-rate generator, every system clock cycle, each rising edge of a timer output, or an edge of the external serial clock pin. The external pin first passes through a two-flop synchronizer, so it can come from outside the chip.

In clock output mode the block also generates the shift clock that drives the serial clock pin. That clock changes level on every basic enable. A receive sampling strobe fires on each low-to-high step of the shift clock. In clock input mode the external pin is the clock. An edge-select bit then decides whether its rising or its falling edge forms both the basic enable and the sampling strobe.

The source, direction and edge settings are captured in reset and while the channel reports idle. Transmit and receive datapaths consume `base_en` and `sample_en`. The baud-rate generator that feeds `baud_tick` is a separate block.

Top module: `sbclk_gen`

## Requirements
- R1: While `rst` is high, `base_en` and `sample_en` are 0 and `sclk_out` is 1 at every following edge, and the baud divider returns to its zero state.
- R2: With source code 00 (baud), `base_en` is high for one cycle on every second sampled `baud_tick`. After reset the first pulse comes from the second tick. `base_en` is high in the cycle after the edge that samples that tick.
- R3: With source code 01 (system clock) in output mode, `base_en` is high on every cycle after reset.
- R4: With source code 10 (timer), `base_en` is high for one cycle in the cycle after the edge that first samples `timer_out` high after it was low.
- R5: With source code 11 (external) in output mode, a rising edge of `ext_clk_in` gives a `base_en` pulse three clock edges after the edge that first samples the new level. Two of those edges are in the synchronizer.
- R6: In output mode (`clk_dir`=0), `sclk_out` starts at 1 and inverts at the same edge that raises `base_en`. It holds its level in all other cycles.
- R7: In output mode, `sample_en` goes high together with `base_en` only when `sclk_out` goes from 0 to 1.
- R8: In input mode (`clk_dir`=1), `base_en` and `sample_en` pulse together on the synchronized external edge, with the same latency as R5. `edge_sel`=0 picks the rising edge and `edge_sel`=1 the falling edge, whatever the source code. `sclk_out` stays at 1.
- R9: A held level on `ext_clk_in` gives exactly one single-cycle pulse per edge.
- R10: `src_sel`, `clk_dir` and `edge_sel` are captured at every edge where `rst` or `chan_idle` is high. Changes made while `chan_idle` is 0 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source code: 00 baud/2, 01 system clock, 10 timer, 11 external pin |
| clk_dir | input | 1 | 0: shift clock driven out, 1: external pin is the clock |
| edge_sel | input | 1 | Input mode edge: 0 rising, 1 falling |
| chan_idle | input | 1 | Channel idle; settings may be captured |
| baud_tick | input | 1 | One-cycle tick from the baud-rate generator |
| timer_out | input | 1 | Timer output level |
| ext_clk_in | input | 1 | Asynchronous external serial clock pin |
| base_en | output | 1 | Basic clock enable |
| sclk_out | output | 1 | Generated shift clock level (output mode) |
| sample_en | output | 1 | Receive data sampling strobe |

## Verification
All three outputs are registered. A baud tick, a timer rise or the system-clock source therefore shows on `base_en` in the cycle after the edge that samples it. An external pin edge shows two cycles later than that, after the two synchronizer flops. The driver changes inputs on falling edges only. At each rising edge it moves a timing model built from these latencies by one step and queues the expected output triple. The monitor compares that triple at the next falling edge, so every check lands in the cycle in which the result is due.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

    typedef enum logic [1:0] {
        SRC_BAUD = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_TMR  = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    typedef struct packed {
        src_e src;
        logic dir;   // 1: pin is an input clock
        logic fall;  // input mode edge choice
    } cfg_t;

    typedef struct packed {
        logic base;
        logic sclk;
        logic samp;
    } clk_out_t;

    localparam clk_out_t OUT_RESET = '{base: 1'b0, sclk: 1'b1, samp: 1'b0};

    function automatic logic pick_edge(input logic lvl, input logic prev, input logic fall);
        return fall ? (prev & ~lvl) : (lvl & ~prev);
    endfunction

endpackage

// File: rtl/sbcg_edge.sv
module sbcg_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fall_sel,
    output logic pulse
);
    import sbcg_pkg::*;

    logic lvl;
    logic prev_q;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = din;
        end else begin : g_sync
            logic [STAGES-1:0] sreg;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sreg <= '0;
                end else begin
                    sreg[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        sreg[i] <= sreg[i-1];
                    end
                end
            end
            assign lvl = sreg[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign pulse = pick_edge(lvl, prev_q, fall_sel);

    // R9: an edge never yields a pulse longer than one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/sbcg_baud_div.sv
module sbcg_baud_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic pulse
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign pulse = en & tick & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: divided output never fires on back-to-back cycles
    a_r2_divided_spacing: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/sbclk_gen.sv
module sbclk_gen #(
    parameter int BAUD_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       clk_dir,
    input  logic       edge_sel,
    input  logic       chan_idle,
    input  logic       baud_tick,
    input  logic       timer_out,
    input  logic       ext_clk_in,
    output logic       base_en,
    output logic       sclk_out,
    output logic       sample_en
);
    import sbcg_pkg::*;

    cfg_t     cfg_q;
    cfg_t     cfg_in;
    clk_out_t out_q;
    clk_out_t out_d;

    logic baud_p, tmr_p, ext_p, src_p, fire;
    logic ext_fall;

    assign cfg_in   = '{src: src_e'(src_sel), dir: clk_dir, fall: edge_sel};
    assign ext_fall = cfg_q.dir & cfg_q.fall;

    always_ff @(posedge clk) begin
        if (rst || chan_idle) cfg_q <= cfg_in;
    end

    sbcg_baud_div #(.DIV(BAUD_DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg_q.src == SRC_BAUD),
        .tick  (baud_tick),
        .pulse (baud_p)
    );

    sbcg_edge #(.STAGES(0)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .din      (timer_out),
        .fall_sel (1'b0),
        .pulse    (tmr_p)
    );

    sbcg_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst      (rst),
        .din      (ext_clk_in),
        .fall_sel (ext_fall),
        .pulse    (ext_p)
    );

    always_comb begin
        unique case (cfg_q.src)
            SRC_BAUD: src_p = baud_p;
            SRC_SYS:  src_p = 1'b1;
            SRC_TMR:  src_p = tmr_p;
            default:  src_p = ext_p;
        endcase
        fire = cfg_q.dir ? ext_p : src_p;

        out_d.base = fire;
        if (cfg_q.dir) begin
            out_d.sclk = 1'b1;
            out_d.samp = fire;
        end else begin
            out_d.sclk = fire ? ~out_q.sclk : out_q.sclk;
            out_d.samp = fire & ~out_q.sclk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= OUT_RESET;
        else     out_q <= out_d;
    end

    assign base_en   = out_q.base;
    assign sclk_out  = out_q.sclk;
    assign sample_en = out_q.samp;

    // R3: system clock source in output mode enables every cycle
    a_r3_sys_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src == SRC_SYS && !cfg_q.dir) |=> base_en);

    // R6: in output mode the shift clock flips with each enable
    a_r6_toggle_on_enable: assert property (@(posedge clk) disable iff (rst)
        (base_en && !$past(cfg_q.dir)) |-> (sclk_out != $past(sclk_out)));

    // R7: sampling strobe in output mode only on a low-to-high step
    a_r7_sample_on_rise: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !$past(cfg_q.dir)) |-> (sclk_out && !$past(sclk_out)));

    // R7/R8: a strobe always travels with an enable
    a_r7_sample_with_base: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> base_en);

    // R8: input mode leaves the shift clock high
    a_r8_input_sclk_high: assert property (@(posedge clk) disable iff (rst)
        cfg_q.dir |=> sclk_out);

    // R10: settings stay put while the channel is busy
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !chan_idle |=> $stable(cfg_q));

endmodule

// File: tb/sbclk_gen_test.sv
module sbclk_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'b01;
    logic       clk_dir = 1'b0;
    logic       edge_sel = 1'b0;
    logic       chan_idle = 1'b1;
    logic       baud_tick = 1'b0;
    logic       timer_out = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       base_en, sclk_out, sample_en;

    always #10 clk = ~clk;  // 50 MHz

    sbclk_gen uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .clk_dir(clk_dir),
        .edge_sel(edge_sel), .chan_idle(chan_idle), .baud_tick(baud_tick),
        .timer_out(timer_out), .ext_clk_in(ext_clk_in),
        .base_en(base_en), .sclk_out(sclk_out), .sample_en(sample_en)
    );

    typedef struct {
        logic  base;
        logic  sclk;
        logic  samp;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // timing model state, built from the requirement latencies
    logic [1:0] m_src = 2'b01;
    logic m_dir = 0, m_fall = 0, m_div = 0, m_tprev = 0;
    logic m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic m_base = 0, m_sclk = 1, m_samp = 0;

    task automatic model_edge();
        logic ep, p;
        if (rst) begin
            m_src = src_sel; m_dir = clk_dir; m_fall = edge_sel;
            m_div = 0; m_tprev = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_base = 0; m_sclk = 1; m_samp = 0;
        end else begin
            ep = (m_dir && m_fall) ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
            case (m_src)
                2'b00:   p = baud_tick && m_div;
                2'b01:   p = 1'b1;
                2'b10:   p = timer_out && !m_tprev;
                default: p = ep;
            endcase
            if (m_dir) p = ep;
            m_base = p;
            if (m_dir) begin
                m_samp = p; m_sclk = 1'b1;
            end else begin
                m_samp = p && !m_sclk;
                if (p) m_sclk = !m_sclk;
            end
            if (m_src == 2'b00 && baud_tick) m_div = !m_div;
            m_tprev = timer_out;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_in;
            if (chan_idle) begin
                m_src = src_sel; m_dir = clk_dir; m_fall = edge_sel;
            end
        end
    endtask

    // driver: one clock step, expected result queued for the monitor
    task automatic step(input string tag);
        exp_t e;
        @(posedge clk);
        model_edge();
        e.base = m_base; e.sclk = m_sclk; e.samp = m_samp; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (base_en !== e.base || sclk_out !== e.sclk || sample_en !== e.samp) begin
                n_fail++;
                $display("FAIL %s: got base=%b sclk=%b samp=%b, expected base=%b sclk=%b samp=%b",
                         e.tag, base_en, sclk_out, sample_en, e.base, e.sclk, e.samp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        steps(3, "R1 reset");
        rst = 0;
        // R3, R6, R7: system clock source, output mode
        steps(8, "R3 R6 R7 sysclk");

        // R2: baud source, divider from reset
        rst = 1; src_sel = 2'b00;
        steps(2, "R1 reset baud");
        rst = 0;
        for (int i = 0; i < 8; i++) begin
            baud_tick = 1; step("R2 baud tick");
            baud_tick = 0; steps(2, "R2 baud gap");
        end
        baud_tick = 1; steps(6, "R2 R7 back-to-back ticks");
        baud_tick = 0;

        // R4: timer rising edges
        src_sel = 2'b10; step("R4 switch");
        timer_out = 1; steps(3, "R4 timer high");
        timer_out = 0; steps(2, "R4 timer low");
        timer_out = 1; step("R4 timer short");
        timer_out = 0; steps(2, "R4 timer low");
        for (int i = 0; i < 4; i++) begin
            timer_out = ~timer_out; step("R4 timer toggle");
        end
        timer_out = 0;

        // R5, R9: external source in output mode
        src_sel = 2'b11; step("R5 switch");
        for (int i = 0; i < 3; i++) begin
            ext_clk_in = 1; steps(5, "R5 R9 ext high");
            ext_clk_in = 0; steps(5, "R5 R9 ext low");
        end

        // R8: input mode, rising then falling edge, source code ignored
        clk_dir = 1; edge_sel = 0; src_sel = 2'b01; step("R8 switch");
        for (int i = 0; i < 3; i++) begin
            ext_clk_in = 1; steps(4, "R8 rising");
            ext_clk_in = 0; steps(4, "R8 rising");
        end
        edge_sel = 1; step("R8 switch fall");
        for (int i = 0; i < 3; i++) begin
            ext_clk_in = 1; steps(4, "R8 falling");
            ext_clk_in = 0; steps(4, "R8 falling");
        end

        // R10: settings ignored while busy, taken when idle again
        clk_dir = 0; edge_sel = 0; src_sel = 2'b01; step("R10 idle capture");
        chan_idle = 0; src_sel = 2'b10; clk_dir = 1;
        steps(6, "R10 busy change ignored");
        chan_idle = 1; steps(6, "R10 idle capture");

        done = 1;
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule